// File: doc/BRIEF.md
# Eight-Byte Page Program Sequencer

This block sits on the host write bus of a flash-style memory and turns a fixed nine-write command into one page programming request. A host write carries an address, a data byte and a strobe. When the sequencer is idle, a write of the setup opcode 8Bh arms it. Each of the next eight accepted writes stores its data byte in the page lane selected by the three lowest address bits. When the eighth byte is stored, the block pulses a start signal to the programming engine. At that point it also presents the whole page, the page base address and a mask of the lanes that were loaded.

Commands are honoured only while the device is configured for byte-wide access and the programming engine is not busy. All other writes are ignored. The command aborts with a one-cycle error pulse in two cases: a data write that targets a lane already loaded, or a data write whose address lies outside the page of the first byte. After an abort the sequencer waits for a new setup opcode.

Top module: `page8_prog_seq`

## Requirements
- R1: After reset, start and err are 0 and page_mask, page_base and page_data are all zero.
- R2: While idle, an accepted write whose data is not 8Bh leaves the block idle: later data writes load nothing until a write of 8Bh arrives.
- R3: After the setup write, each accepted write stores wr_data in page_data bits [8*k+7:8*k] and sets page_mask bit k, where k is wr_addr[2:0].
- R4: The eighth accepted data write after setup raises start for exactly one cycle, on the clock edge that samples that write. At that moment page_mask is FFh and page_data holds all eight bytes. The block is then idle.
- R5: page_base takes the first data write's address with bits [2:0] cleared, on the edge that samples that write.
- R6: A data write (not the first) whose lane bit is already set in page_mask pulses err for one cycle, clears page_mask, returns the block to idle, and stores nothing.
- R7: A data write (not the first) whose address with bits [2:0] cleared differs from page_base is handled exactly as in R6.
- R8: A write with busy high is ignored: outputs and sequence progress are unchanged, in idle and during loading.
- R9: A write with byte_mode low is ignored in the same way, including a setup opcode.
- R10: After completion or abort, page_mask, page_data and page_base hold their values until the next accepted write changes them. An accepted setup write clears page_mask to zero.
- R11: start and err are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | High when the device is configured for byte-wide access |
| busy | input | 1 | Programming engine busy; blocks all writes |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Host byte address |
| wr_data | input | 8 | Host write data |
| start | output | 1 | One-cycle pulse that launches page programming |
| err | output | 1 | One-cycle pulse on an aborted sequence |
| page_base | output | ADDR_W | Page address with bits [2:0] zero |
| page_data | output | 64 | Page bytes, lane k in bits [8k+7:8k] |
| page_mask | output | 8 | Lanes loaded so far |

## Verification
Every output is registered. The effect of a write sampled at a rising edge therefore shows right after that edge, and start and err fall again at the following edge. The bench drives each write on a falling edge, waits for the next rising edge, and compares all five outputs a little after it. The reference model is stepped once per write, so the expected values always describe the same cycle as the observed ones. Writes blocked by busy or byte_mode are checked in that same cycle. This shows that nothing moved, including the one-cycle pulses.

// File: rtl/page8_prog_seq.sv
module page8_prog_seq #(
  parameter int ADDR_W = 24,
  parameter logic [7:0] SETUP_OP = 8'h8B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              busy,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              start,
  output logic              err,
  output logic [ADDR_W-1:0] page_base,
  output logic [63:0]       page_data,
  output logic [7:0]        page_mask
);
  localparam int LANES = 8;
  localparam int OFF_W = $clog2(LANES);

  logic             loading;
  logic [OFF_W-1:0] cnt;

  wire              accept = wr_en & ~busy & byte_mode;
  wire [OFF_W-1:0]  off    = wr_addr[OFF_W-1:0];
  wire [ADDR_W-1:0] row    = {wr_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  wire              first  = (cnt == '0);
  wire              bad    = !first && (page_mask[off] || row != page_base);
  wire              last   = (cnt == OFF_W'(LANES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading   <= 1'b0;
      cnt       <= '0;
      start     <= 1'b0;
      err       <= 1'b0;
      page_base <= '0;
      page_data <= '0;
      page_mask <= '0;
    end else begin
      start <= 1'b0;
      err   <= 1'b0;
      if (accept) begin
        if (!loading) begin
          if (wr_data == SETUP_OP) begin
            loading   <= 1'b1;
            cnt       <= '0;
            page_mask <= '0;
          end
        end else if (bad) begin
          loading   <= 1'b0;
          err       <= 1'b1;
          page_mask <= '0;
        end else begin
          page_data[{off, 3'b000} +: 8] <= wr_data;
          page_mask[off] <= 1'b1;
          if (first) page_base <= row;
          cnt <= cnt + 1'b1;
          if (last) begin
            loading <= 1'b0;
            start   <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/page8_prog_seq_chk.sv
module page8_prog_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_mode,
  input logic              busy,
  input logic              wr_en,
  input logic              start,
  input logic              err,
  input logic [ADDR_W-1:0] page_base,
  input logic [63:0]       page_data,
  input logic [7:0]        page_mask
);
  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(start && err));
  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> !start);
  // R4
  start_full_chk: assert property (@(posedge clk) disable iff (!rst_n) start |-> page_mask == 8'hFF);
  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> page_mask == 8'h00);
  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) err |=> !err);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(page_mask) && $stable(page_data) && $stable(page_base) && !start && !err);
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_mode |=> $stable(page_mask) && $stable(page_data) && $stable(page_base) && !start && !err);
  // R10
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(page_mask) && $stable(page_data) && $stable(page_base));
endmodule

bind page8_prog_seq page8_prog_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/page8_prog_seq_tb.sv
module page8_prog_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_mode = 1'b1, busy = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic start, err;
  logic [ADDR_W-1:0] page_base;
  logic [63:0] page_data;
  logic [7:0] page_mask;

  int checks = 0, errors = 0;

  logic m_load = 1'b0;
  int   m_cnt = 0;
  logic exp_start = 1'b0, exp_err = 1'b0;
  logic [ADDR_W-1:0] exp_base = '0;
  logic [63:0] exp_data = '0;
  logic [7:0] exp_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page8_prog_seq #(.ADDR_W(ADDR_W)) u_dut (.*);

  function automatic logic [ADDR_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:3], 3'b000};
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic en, input logic b, input logic bm,
                       input logic [ADDR_W-1:0] a, input logic [7:0] d);
    exp_start = 1'b0;
    exp_err = 1'b0;
    if (en && !b && bm) begin
      if (!m_load) begin
        if (d == 8'h8B) begin
          m_load = 1'b1;
          m_cnt = 0;
          exp_mask = '0;
        end
      end else if (m_cnt != 0 && (exp_mask[a[2:0]] || row_of(a) != exp_base)) begin
        m_load = 1'b0;
        exp_err = 1'b1;
        exp_mask = '0;
      end else begin
        exp_data[a[2:0]*8 +: 8] = d;
        exp_mask[a[2:0]] = 1'b1;
        if (m_cnt == 0) exp_base = row_of(a);
        m_cnt++;
        if (m_cnt == 8) begin
          m_load = 1'b0;
          exp_start = 1'b1;
        end
      end
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "start", 64'(start), 64'(exp_start));
    chk(tag, "err", 64'(err), 64'(exp_err));
    chk(tag, "page_mask", 64'(page_mask), 64'(exp_mask));
    chk(tag, "page_data", page_data, exp_data);
    chk(tag, "page_base", 64'(page_base), 64'(exp_base));
  endtask

  task automatic step(input logic en, input logic b, input logic bm,
                      input logic [ADDR_W-1:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = en; busy = b; byte_mode = bm; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    model(en, b, bm, a, d);
    wr_en = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R4 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] base;
    logic [2:0] perm [8];
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b1, '0, '0, "R1");

    // R2: a non-setup value in idle arms nothing
    step(1'b1, 1'b0, 1'b1, 24'h000100, 8'h8A, "R2");
    step(1'b1, 1'b0, 1'b1, 24'h000101, 8'h11, "R2");
    chk("R2", "mask idle", 64'(page_mask), 64'h0);

    // R9: setup with byte_mode low is ignored
    step(1'b1, 1'b0, 1'b0, 24'h000200, 8'h8B, "R9");
    step(1'b1, 1'b0, 1'b1, 24'h000203, 8'h22, "R9");
    chk("R9", "mask idle", 64'(page_mask), 64'h0);

    // Directed full page, reverse lane order, busy and mode writes mixed in
    step(1'b1, 1'b0, 1'b1, 24'h0ABC00, 8'h8B, "R2");
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'b0, 1'b1, 24'h0ABC40 | 24'(7 - i), 8'(8'hA0 + i), i == 0 ? "R5" : (i == 7 ? "R4" : "R3"));
      if (i == 2) begin
        step(1'b1, 1'b1, 1'b1, 24'h0ABC40, 8'h8B, "R8");
        step(1'b1, 1'b0, 1'b0, 24'h0ABC41, 8'h55, "R9");
      end
    end
    chk("R4", "base", 64'(page_base), 64'h0ABC40);
    step(1'b0, 1'b0, 1'b1, '0, '0, "R4");
    step(1'b0, 1'b0, 1'b1, '0, '0, "R10");
    chk("R10", "mask held", 64'(page_mask), 64'hFF);
    step(1'b1, 1'b0, 1'b1, 24'h000000, 8'h8B, "R10");
    chk("R10", "mask cleared", 64'(page_mask), 64'h0);

    // R6: duplicate lane
    step(1'b1, 1'b0, 1'b1, 24'h001005, 8'h01, "R6");
    step(1'b1, 1'b0, 1'b1, 24'h001005, 8'h02, "R6");
    chk("R6", "err", 64'(err), 64'h1);
    step(1'b1, 1'b0, 1'b1, 24'h001006, 8'h03, "R6");

    // R7: upper bits differ from page
    step(1'b1, 1'b0, 1'b1, 24'h000000, 8'h8B, "R7");
    step(1'b1, 1'b0, 1'b1, 24'h002000, 8'h04, "R7");
    step(1'b1, 1'b0, 1'b1, 24'h002009, 8'h05, "R7");
    chk("R7", "err", 64'(err), 64'h1);

    // Random sequences
    for (int it = 0; it < 300; it++) begin
      int fault, fpos;
      base = 24'($urandom) & ~24'h7;
      for (int k = 0; k < 8; k++) perm[k] = 3'(k);
      for (int k = 7; k > 0; k--) begin
        int j;
        logic [2:0] t;
        j = int'($urandom % (k + 1));
        t = perm[k]; perm[k] = perm[j]; perm[j] = t;
      end
      fault = int'($urandom % 4);
      fpos = 1 + int'($urandom % 7);
      if ($urandom % 3 == 0) step(1'b1, 1'b0, 1'b1, base, 8'($urandom), "R2");
      step(1'b1, 1'b0, 1'b1, base, 8'h8B, "R2");
      for (int k = 0; k < 8; k++) begin
        logic [ADDR_W-1:0] a;
        a = base | 24'(perm[k]);
        if (k == fpos && fault == 0) a = base | 24'(perm[$urandom % k]);
        if (k == fpos && fault == 1) a = a ^ (24'h8 << ($urandom % (ADDR_W - 3)));
        if ($urandom % 5 == 0) step(1'b1, 1'b1, 1'b1, a ^ 24'h1, 8'h8B, "R8");
        if ($urandom % 7 == 0) step(1'b1, 1'b0, 1'b0, a ^ 24'h2, 8'($urandom), "R9");
        step(1'b1, 1'b0, 1'b1, a, 8'($urandom), (k == fpos && fault == 0) ? "R6" :
             (k == fpos && fault == 1) ? "R7" : (k == 7 ? "R4" : "R3"));
        if (k == fpos && fault < 2) break;
      end
      if ($urandom % 2 == 0) step(1'b0, 1'b0, 1'b1, '0, '0, "R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule